// File: doc/BRIEF.md
# I2C Master Byte Shifter

This block is the data engine of an I2C master. Once the START condition is on the bus, it moves one transfer across the SDA line. As transmitter it presents a programmable number of bits, MSB first. As receiver it samples that many bits from the slave. Optionally it then runs one more clock for the acknowledge. It does not make the SCL waveform itself. It raises `scl_run` while a transfer is in progress, and it reacts to one-cycle `scl_rise` and `scl_fall` ticks from an external clock generator. The SDA output is open-drain: `sda_low` high means pull the line low, and low means release it.

A transfer is requested through a valid/ready handshake. `start_valid` is taken in the cycle where `start_ready` is also high. `start_ready` stays low for the whole transfer. A source that sees `start_ready` low must hold `start_valid` and its direction, acknowledge-enable and data inputs until the handshake completes. Those inputs are sampled only in the accepting cycle.

The number of bits comes from a 3-bit bit-count field. Software writes it with `code_wr`, and it keeps that value from one transfer to the next. A pulse on `start_cond` marks that a START was generated and sets the field back to code 0, which means 8 bits. An address byte that follows a START is therefore always a full byte. When the transfer ends, `done` pulses for one cycle. `rx_data` and `ack_status` then hold the results.

Top module: `i2c_master_shifter`

## Requirements
- R1: `start_ready` is high exactly when no transfer is in progress, and `scl_run` is its complement. A request is accepted in a cycle where `start_valid` and `start_ready` are both high.
- R2: The bit-count field is decoded at acceptance. Code 0 gives 8 data clocks, and codes 1 to 7 give that many data clocks. One data clock is one `scl_rise` tick followed by one `scl_fall` tick.
- R3: A `start_cond` pulse sets the bit-count field to code 0. It wins over a `code_wr` in the same cycle.
- R4: Apart from `start_cond`, the field keeps the value of the last `code_wr` across any number of transfers.
- R5: As transmitter, the block sends the top n bits of `tx_byte`, MSB first. `sda_low` is the inverse of the current bit, and it changes only while SCL is low, that is, never between a consumed `scl_rise` and the next `scl_fall`.
- R6: As receiver, the block samples `sda_in` on each data `scl_rise` and keeps `sda_low` at 0 during data bits. `rx_data` holds the n received bits right-aligned, with the first bit at position n-1 and zeros above.
- R7: With acknowledge enabled, exactly one extra clock follows the data bits. As transmitter the block releases SDA during that clock and stores `sda_in` at its rise in `ack_status` (0 means acknowledged).
- R8: As receiver with acknowledge enabled, `sda_low` is 1 throughout the acknowledge clock, and `ack_status` records 0.
- R9: With acknowledge disabled, no extra clock is run after the data bits, and `ack_status` keeps its previous value.
- R10: `done` is high for exactly one cycle, in the cycle after the one in which the final `scl_fall` tick is taken. In that same cycle `start_ready` is high again.
- R11: After reset, `start_ready` and `ack_status` are 1, and `scl_run`, `sda_low`, `done` and `rx_data` are 0. The field is code 0. While idle, `sda_low` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Transfer request |
| start_ready | output | 1 | High when a request can be accepted |
| dir_tx | input | 1 | 1 = transmit, 0 = receive; sampled at acceptance |
| ack_en | input | 1 | 1 = add an acknowledge clock; sampled at acceptance |
| code_wr | input | 1 | Write strobe for the bit-count field |
| bit_code | input | 3 | New bit-count code (0 = 8 bits) |
| start_cond | input | 1 | Pulse marking a generated START; sets the field to 0 |
| tx_byte | input | 8 | Transmit data; sampled at acceptance |
| scl_rise | input | 1 | SCL rising-edge tick from the clock generator |
| scl_fall | input | 1 | SCL falling-edge tick from the clock generator |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_run | output | 1 | Asks the clock generator to run SCL |
| sda_low | output | 1 | Open-drain drive: 1 pulls SDA low |
| rx_data | output | 8 | Received bits, right-aligned |
| ack_status | output | 1 | SDA level sampled in the acknowledge clock |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions rely on the clock generator obeying three rules. It issues ticks only while `scl_run` is high. It never raises `scl_rise` and `scl_fall` in the same cycle. It alternates them, starting with a rise after each acceptance. They also assume that `code_wr` and `start_cond` do not coincide with an accepting cycle. The bench's tick model comes from a free-running divider that resets whenever `scl_run` is low. Every field write and START pulse is issued while the block is idle and at least one cycle away from a request, so the stimulus stays inside these rules.

// File: rtl/i2c_shifter_pkg.sv
package i2c_shifter_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_ACK  = 2'd2
  } phase_t;
endpackage

// File: rtl/i2c_bitcount_field.sv
module i2c_bitcount_field #(
  parameter int DATA_W = 8,
  parameter int CODE_W = $clog2(DATA_W),
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] bit_code,
  input  logic              start_cond,
  output logic [CNT_W-1:0]  nbits
);
  logic [CODE_W-1:0] field_q;

  // START has priority over a software write in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)          field_q <= '0;
    else if (start_cond) field_q <= '0;
    else if (code_wr)    field_q <= bit_code;
  end

  // code zero stands for a full data word
  always_comb begin
    if (field_q == '0) nbits = CNT_W'(DATA_W);
    else               nbits = CNT_W'(field_q);
  end
endmodule

// File: rtl/i2c_shift_seq.sv
module i2c_shift_seq
  import i2c_shifter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  input  logic             dir_tx,
  input  logic             ack_en,
  input  logic [CNT_W-1:0] nbits,
  input  logic             scl_rise,
  input  logic             scl_fall,
  output logic             start_ready,
  output logic             load,
  output logic             shift_tx,
  output logic             sample_rx,
  output logic             sample_ack,
  output logic             tx_q,
  output phase_t           phase,
  output logic             done
);
  logic [CNT_W-1:0] left_q;
  logic             ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      left_q <= '0;
      tx_q   <= 1'b0;
      ack_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start_valid) begin
            phase  <= PH_DATA;
            left_q <= nbits;
            tx_q   <= dir_tx;
            ack_q  <= ack_en;
          end
        end
        PH_DATA: begin
          if (scl_fall) begin
            if (left_q == CNT_W'(1)) begin
              if (ack_q) begin
                phase <= PH_ACK;
              end else begin
                phase <= PH_IDLE;
                done  <= 1'b1;
              end
            end else begin
              left_q <= left_q - CNT_W'(1);
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    start_ready = (phase == PH_IDLE);
    load        = start_ready && start_valid;
    shift_tx    = (phase == PH_DATA) && scl_fall;
    sample_rx   = (phase == PH_DATA) && scl_rise && !tx_q;
    sample_ack  = (phase == PH_ACK) && scl_rise;
  end
endmodule

// File: rtl/i2c_shift_path.sv
module i2c_shift_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift_tx,
  input  logic              sample_rx,
  input  logic              sample_ack,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              sda_in,
  output logic              tx_msb,
  output logic [DATA_W-1:0] rx_data,
  output logic              ack_status
);
  logic [DATA_W-1:0] tx_sr;

  always_ff @(posedge clk) begin
    if (!rst_n)        tx_sr <= '0;
    else if (load)     tx_sr <= tx_byte;
    else if (shift_tx) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rx_data <= '0;
    else if (load)      rx_data <= '0;
    else if (sample_rx) rx_data <= {rx_data[DATA_W-2:0], sda_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          ack_status <= 1'b1;
    else if (sample_ack) ack_status <= sda_in;
  end

  assign tx_msb = tx_sr[DATA_W-1];
endmodule

// File: rtl/i2c_master_shifter.sv
module i2c_master_shifter
  import i2c_shifter_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CODE_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic              dir_tx,
  input  logic              ack_en,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] bit_code,
  input  logic              start_cond,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  output logic              scl_run,
  output logic              sda_low,
  output logic [DATA_W-1:0] rx_data,
  output logic              ack_status,
  output logic              done
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] nbits;
  logic             load, shift_tx, sample_rx, sample_ack, tx_q, tx_msb;
  phase_t           phase;

  i2c_bitcount_field #(.DATA_W(DATA_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_field (
    .clk(clk), .rst_n(rst_n), .code_wr(code_wr), .bit_code(bit_code),
    .start_cond(start_cond), .nbits(nbits)
  );

  i2c_shift_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .dir_tx(dir_tx),
    .ack_en(ack_en), .nbits(nbits), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ready(start_ready), .load(load), .shift_tx(shift_tx),
    .sample_rx(sample_rx), .sample_ack(sample_ack), .tx_q(tx_q),
    .phase(phase), .done(done)
  );

  i2c_shift_path #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rst_n(rst_n), .load(load), .shift_tx(shift_tx),
    .sample_rx(sample_rx), .sample_ack(sample_ack), .tx_byte(tx_byte),
    .sda_in(sda_in), .tx_msb(tx_msb), .rx_data(rx_data), .ack_status(ack_status)
  );

  // transmitter pulls low for a zero bit; receiver pulls low to acknowledge
  always_comb begin
    sda_low = ((phase == PH_DATA) && tx_q && !tx_msb) ||
              ((phase == PH_ACK) && !tx_q);
    scl_run = !start_ready;
  end
endmodule

// File: rtl/i2c_shifter_chk.sv
module i2c_shifter_chk #(
  parameter int DATA_W = 8,
  localparam int CODE_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic              dir_tx,
  input logic              ack_en,
  input logic              code_wr,
  input logic [CODE_W-1:0] bit_code,
  input logic              start_cond,
  input logic              scl_rise,
  input logic              scl_fall,
  input logic              scl_run,
  input logic              sda_low,
  input logic              done
);
  localparam int CNT_W = $clog2(DATA_W + 2);

  logic [CODE_W-1:0] fld;
  logic [CNT_W-1:0]  want, rises;
  logic              tx_c, ack_c, scl_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld <= '0; want <= '0; rises <= '0; tx_c <= 1'b0; ack_c <= 1'b0; scl_hi <= 1'b0;
    end else begin
      if (start_cond)   fld <= '0;
      else if (code_wr) fld <= bit_code;
      if (start_valid && start_ready) begin
        want   <= ((fld == '0) ? CNT_W'(DATA_W) : CNT_W'(fld));
        tx_c   <= dir_tx;
        ack_c  <= ack_en;
        rises  <= '0;
        scl_hi <= 1'b0;
      end else if (!start_ready) begin
        if (scl_rise) begin
          rises  <= rises + CNT_W'(1);
          scl_hi <= 1'b1;
        end
        if (scl_fall) scl_hi <= 1'b0;
      end
    end
  end

  assert_ready_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    scl_run == !start_ready);
  assert_clock_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rises == want + CNT_W'(ack_c)));
  assert_sda_still_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hi |-> $stable(sda_low));
  // acknowledge clock: transmitter releases (R7), receiver pulls low (R8)
  assert_ack_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_ready && ack_c && scl_rise && rises == want) |-> (sda_low == !tx_c));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> start_ready);
  assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !sda_low);
endmodule

bind i2c_master_shifter i2c_shifter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
  .dir_tx(dir_tx), .ack_en(ack_en), .code_wr(code_wr), .bit_code(bit_code),
  .start_cond(start_cond), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .scl_run(scl_run), .sda_low(sda_low), .done(done)
);

// File: tb/sim_i2c_master_shifter.sv
module sim_i2c_master_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0, dir_tx = 1'b0, ack_en = 1'b0, code_wr = 1'b0, start_cond = 1'b0;
  logic [2:0] bit_code = '0;
  logic [7:0] tx_byte = '0;
  logic scl_rise = 1'b0, scl_fall = 1'b0;
  logic sda_in, start_ready, scl_run, sda_low, ack_status, done;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] slave_byte = '0;
  logic       slave_ack_low = 1'b0;
  logic [3:0] cur_n = 4'd8;
  logic [2:0] fld_m = '0;
  logic       ack_m = 1'b1;

  logic [2:0] div;
  logic [3:0] rcnt;
  logic [7:0] cap_bits;
  logic       ack_drv, run_d;
  logic       slave_low;

  always #2.5 clk = ~clk;

  i2c_master_shifter u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .dir_tx(dir_tx), .ack_en(ack_en), .code_wr(code_wr), .bit_code(bit_code),
    .start_cond(start_cond), .tx_byte(tx_byte), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_in(sda_in), .scl_run(scl_run), .sda_low(sda_low),
    .rx_data(rx_data), .ack_status(ack_status), .done(done)
  );

  // slave model: data bits for a read, acknowledge for a write
  always_comb begin
    slave_low = 1'b0;
    if (!dir_tx && rcnt < cur_n) slave_low = !slave_byte[7 - rcnt[2:0]];
    if (dir_tx && ack_en && rcnt == cur_n) slave_low = slave_ack_low;
  end
  assign sda_in = !(sda_low || slave_low);

  // clock generator model driven on the falling edge
  always @(negedge clk) begin
    run_d <= scl_run;
    if (!rst_n || !scl_run) begin
      div <= '0; scl_rise <= 1'b0; scl_fall <= 1'b0;
      if (!rst_n) begin rcnt <= '0; cap_bits <= '0; ack_drv <= 1'b0; end
    end else if (!run_d) begin
      div <= 3'd1; rcnt <= '0; cap_bits <= '0; ack_drv <= 1'b0;
      scl_rise <= 1'b0; scl_fall <= 1'b0;
    end else begin
      div      <= div + 3'd1;
      scl_rise <= (div == 3'd3);
      scl_fall <= (div == 3'd7);
      if (div == 3'd3) begin
        if (rcnt < cur_n) cap_bits <= {cap_bits[6:0], sda_in};
        else              ack_drv  <= sda_low;
      end
      if (div == 3'd7) rcnt <= rcnt + 4'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] bits_of(input logic [2:0] code);
    return (code == 3'd0) ? 4'd8 : {1'b0, code};
  endfunction

  function automatic logic [7:0] top_bits(input logic [7:0] v, input logic [3:0] n);
    return v >> (4'd8 - n);
  endfunction

  task automatic write_code(input logic [2:0] c);
    @(negedge clk); code_wr = 1'b1; bit_code = c;
    @(negedge clk); code_wr = 1'b0;
    fld_m = c;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_cond = 1'b1;
    @(negedge clk); start_cond = 1'b0;
    fld_m = '0;
  endtask

  task automatic xfer(input logic tx, input logic ak, input logic [7:0] d,
                      input logic [7:0] s, input logic sack, input string tag);
    int wait_n;
    logic [3:0] n;
    n = bits_of(fld_m);
    @(negedge clk);
    cur_n = n; dir_tx = tx; ack_en = ak; tx_byte = d; slave_byte = s; slave_ack_low = sack;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    chk({tag, " R1 ready low while busy"}, {31'd0, start_ready}, 32'd0);
    wait_n = 0;
    while (done !== 1'b1 && wait_n < 400) begin
      @(negedge clk); wait_n++;
      if (wait_n > 2 && done !== 1'b1)
        if (start_ready !== 1'b0) begin chk({tag, " R1 ready early"}, 32'd1, 32'd0); end
    end
    chk({tag, " R10 done seen"}, {31'd0, done}, 32'd1);
    chk({tag, " R10 ready with done"}, {31'd0, start_ready}, 32'd1);
    chk({tag, " R2 clock count"}, {28'd0, rcnt}, {28'd0, n + {3'd0, ak}});
    if (tx) chk({tag, " R5 sent bits"}, {24'd0, cap_bits & top_bits(8'hFF, n)},
                {24'd0, top_bits(d, n)});
    else    chk({tag, " R6 received"}, {24'd0, rx_data}, {24'd0, top_bits(s, n)});
    if (ak) begin
      if (tx) begin
        chk({tag, " R7 released in ack"}, {31'd0, ack_drv}, 32'd0);
        ack_m = !sack;
      end else begin
        chk({tag, " R8 driven in ack"}, {31'd0, ack_drv}, 32'd1);
        ack_m = 1'b0;
      end
      chk({tag, " R7 ack status"}, {31'd0, ack_status}, {31'd0, ack_m});
    end else begin
      chk({tag, " R9 ack status kept"}, {31'd0, ack_status}, {31'd0, ack_m});
    end
    @(negedge clk);
    chk({tag, " R10 one cycle"}, {31'd0, done}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready", {31'd0, start_ready}, 32'd1);
    chk("R11 scl_run", {31'd0, scl_run}, 32'd0);
    chk("R11 sda_low", {31'd0, sda_low}, 32'd0);
    chk("R11 done", {31'd0, done}, 32'd0);
    chk("R11 ack", {31'd0, ack_status}, 32'd1);
    chk("R11 rx", {24'd0, rx_data}, 32'd0);

    // R11 field resets to 8 bits, R7 write with acknowledge and nack
    xfer(1'b1, 1'b1, 8'hA5, 8'h00, 1'b1, "d1");
    xfer(1'b1, 1'b1, 8'h3C, 8'h00, 1'b0, "d2");
    // R2 shorter count, R6 receive with R8 acknowledge
    write_code(3'd3);
    xfer(1'b0, 1'b1, 8'h00, 8'hB7, 1'b0, "d3");
    // R4 field persists
    xfer(1'b0, 1'b0, 8'h00, 8'h61, 1'b0, "d4");
    xfer(1'b1, 1'b0, 8'hE0, 8'h00, 1'b0, "d5");
    // R3 START returns to 8 bits
    pulse_start();
    xfer(1'b1, 1'b1, 8'h96, 8'h00, 1'b1, "d6");
    // R3 START beats a simultaneous write
    @(negedge clk); code_wr = 1'b1; bit_code = 3'd5; start_cond = 1'b1;
    @(negedge clk); code_wr = 1'b0; start_cond = 1'b0; fld_m = '0;
    xfer(1'b0, 1'b0, 8'h00, 8'h5A, 1'b0, "d7");
    // corner counts of one and seven bits, R9 no ack clock
    write_code(3'd1);
    xfer(1'b1, 1'b0, 8'h80, 8'h00, 1'b0, "d8");
    xfer(1'b0, 1'b1, 8'h00, 8'h80, 1'b0, "d9");
    write_code(3'd7);
    xfer(1'b1, 1'b1, 8'h01, 8'h00, 1'b0, "d10");
    xfer(1'b0, 1'b0, 8'h00, 8'hFE, 1'b0, "d11");

    for (int i = 0; i < 40; i++) begin
      int pick;
      pick = int'($urandom_range(0, 3));
      if (pick == 0) pulse_start();
      else if (pick == 1) write_code(3'($urandom_range(0, 7)));
      xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom),
           8'($urandom), 1'($urandom_range(0, 1)), "rnd");
    end

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule